// File: doc/BRIEF.md
# PCM Voice Serial Port

This block carries linear PCM voice samples between a parallel sample interface and a four-wire serial voice bus made of a bit clock, a frame sync, a data-out line and a data-in line. Each frame holds one voice slot. The slot is 8 to 16 bits wide and is sent most significant bit first. Outgoing bits change on rising bit-clock edges. Incoming bits are captured on falling edges. The data-out enable releases the line once the slot's last bit has been sent.

The port can act as bus master or as slave. As master, it derives the bit clock from the system clock with an integer half-period divider and drives both the bit clock and the frame sync. As slave, it takes both from the bus through two-flop synchronizers and detects their edges in the system clock domain. Frame sync is either a short pulse, one bit period wide, just ahead of the first data bit, or a long pulse that covers the whole slot. A receive-only burst setting keeps data out released and stops transmit requests. Reception continues as normal in that setting.

On the parallel side, the host supplies one sample per frame. It answers a request pulse that the block raises at the start of every slot, and the sample it writes then goes out in the following frame. If no sample has arrived by the next slot start, the block sends zeros. Each received sample is presented with a one-cycle strobe.

Top module: `pcm_voice_port`

## Requirements
- R1: While reset is held, bit clock out, frame sync out, the data-out enable, the receive strobe and the transmit request are all 0.
- R2: As master, each high phase and each low phase of the bit clock lasts exactly `cfg_half_div` system clock cycles.
- R3: As master with short sync (`cfg_long_sync`=0), frame sync is high only during bit period `cfg_frame_len`-1, which is the period just before data bit 0. A frame is `cfg_frame_len` bit periods long, and data bit 0 occupies period 0.
- R4: As master with long sync (`cfg_long_sync`=1), frame sync is high during exactly the periods 0 to `cfg_slot_bits`-1.
- R5: Bits [`cfg_slot_bits`-1:0] of the transmit sample are sent most significant bit first, with bit period k carrying bit `cfg_slot_bits`-1-k. As master, data out changes only together with a rising bit-clock edge.
- R6: The data-out enable is 1 during periods 0 to `cfg_slot_bits`-1. It returns to 0 at the rising edge that ends the last bit period and stays 0 for the rest of the frame.
- R7: Data in is captured on the falling edge of each slot period. After the last slot bit, `rx_data` holds the sample right-justified with its upper bits zero, and `rx_valid` is high for exactly one cycle.
- R8: `tx_req` pulses for one cycle at the start of every slot. A sample written with `tx_valid` after that pulse is sent in the next frame. If no sample is written, the next frame carries all zeros.
- R9: As slave (`cfg_master`=0), `bclk_oe` and `fsync_oe` are 0. The block aligns its frame to the incoming sync and then sends and receives in the correct periods. With short sync, bit 0 starts at the first rising edge after a falling edge at which sync is seen high. With long sync, the period in which sync is first seen high is bit 0.
- R10: With `cfg_burst`=1, the data-out enable never rises and `tx_req` never pulses. Reception works as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master | input | 1 | 1 = drive bit clock and sync, 0 = take them from the bus |
| cfg_long_sync | input | 1 | 0 = one-period sync before bit 0, 1 = sync spans the slot |
| cfg_burst | input | 1 | Receive-only setting |
| cfg_slot_bits | input | $clog2(SAMPLE_W+1) | Slot width in bits, 8 to SAMPLE_W |
| cfg_frame_len | input | FRAME_W | Frame length in bit periods, greater than the slot width |
| cfg_half_div | input | DIV_W | Master bit-clock half period in system cycles, at least 1 |
| tx_data | input | SAMPLE_W | Transmit sample, right-justified |
| tx_valid | input | 1 | Writes `tx_data` as the next frame's sample |
| tx_req | output | 1 | One-cycle request at each slot start |
| rx_data | output | SAMPLE_W | Last received sample, right-justified |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| bclk_o | output | 1 | Bit clock driven as master |
| bclk_oe | output | 1 | Drive enable for the bit clock |
| bclk_i | input | 1 | Bit clock from the bus as slave |
| fsync_o | output | 1 | Frame sync driven as master |
| fsync_oe | output | 1 | Drive enable for the frame sync |
| fsync_i | input | 1 | Frame sync from the bus as slave |
| dout_o | output | 1 | Serial data out |
| dout_oe | output | 1 | Drive enable for data out |
| din_i | input | 1 | Serial data in |

## Verification
The bound checker checks several properties on every cycle:
- `tx_req` and `rx_valid` are single-cycle pulses.
- As master, data out and frame sync change only on a rising bit-clock edge.
- As slave, both bus drive enables stay low.
- In burst mode, the data-out enable never rises and no request is issued.

Other behaviour depends on the order of whole frames, so only the bench scenarios can show it:
- the exact bit values and their order in the slot;
- where sync falls within the frame;
- the cycle in which the drive enable is released;
- right-justification of received samples;
- one-frame-ahead transmit buffering and zero fill on underrun;
- frame alignment as slave.

// File: rtl/pcm_voice_pkg.sv
package pcm_voice_pkg;
  // Bit-clock events as seen in the system clock domain, plus the bus
  // sync and data-in values that belong to them.
  typedef struct packed {
    logic rise;
    logic fall;
    logic sync;
    logic din;
  } pcm_evt_t;
endpackage

// File: rtl/pcm_bclk_master.sv
module pcm_bclk_master #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             bclk,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] cnt;
  logic             tick;

  assign tick = run && (cnt == half - 1'b1);
  assign rise = tick & ~bclk;
  assign fall = tick & bclk;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      bclk <= 1'b0;
    end else if (tick) begin
      cnt  <= '0;
      bclk <= ~bclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pcm_bus_sampler.sv
module pcm_bus_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bclk_in,
  input  logic sync_in,
  input  logic din_in,
  output logic rise,
  output logic fall,
  output logic sync_s,
  output logic din_s
);
  // One synchronizer chain per bus line: {bclk, sync, din}
  logic [STAGES-1:0][2:0] pipe;
  logic                   bclk_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe      <= '0;
      bclk_last <= 1'b0;
    end else begin
      pipe[0] <= {bclk_in, sync_in, din_in};
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      bclk_last <= pipe[STAGES-1][2];
    end
  end

  assign rise   = pipe[STAGES-1][2] & ~bclk_last;
  assign fall   = ~pipe[STAGES-1][2] & bclk_last;
  assign sync_s = pipe[STAGES-1][1];
  assign din_s  = pipe[STAGES-1][0];
endmodule

// File: rtl/pcm_slot_engine.sv
module pcm_slot_engine
  import pcm_voice_pkg::*;
#(
  parameter int W     = 16,
  parameter int CNT_W = 8,
  parameter int NB_W  = $clog2(W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             master,
  input  logic             long_sync,
  input  logic             burst,
  input  logic [NB_W-1:0]  slot_bits,
  input  logic [CNT_W-1:0] frame_len,
  input  pcm_evt_t         evt,
  input  logic [W-1:0]     tx_data,
  input  logic             tx_valid,
  output logic             fsync_o,
  output logic             dout_o,
  output logic             dout_oe,
  output logic             tx_req,
  output logic [W-1:0]     rx_data,
  output logic             rx_valid
);
  logic [CNT_W-1:0] bit_cnt, nxt, last, eff, nbits;
  logic [W-1:0]     pend, sh, load_val, mask;
  logic [W-2:0]     rx_sh;
  logic             pend_vld, fs_prev, fs_edge, in_slot_nxt;

  assign last        = frame_len - 1'b1;
  assign nbits       = CNT_W'(slot_bits);
  assign nxt         = (bit_cnt >= last) ? '0 : bit_cnt + 1'b1;
  assign in_slot_nxt = nxt < nbits;
  assign load_val    = pend_vld ? (pend << (NB_W'(W) - slot_bits)) : '0;
  assign mask        = {W{1'b1}} >> (NB_W'(W) - slot_bits);
  assign fs_edge     = evt.sync & ~fs_prev;
  // With long sync as slave, the period in which sync is first seen is bit 0
  assign eff         = (!master && long_sync && fs_edge) ? '0 : bit_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt  <= '1;
      pend     <= '0;
      pend_vld <= 1'b0;
      sh       <= '0;
      fsync_o  <= 1'b0;
      dout_o   <= 1'b0;
      dout_oe  <= 1'b0;
      tx_req   <= 1'b0;
      rx_sh    <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      fs_prev  <= 1'b0;
    end else begin
      tx_req   <= 1'b0;
      rx_valid <= 1'b0;
      if (tx_valid) begin
        pend     <= tx_data;
        pend_vld <= 1'b1;
      end
      if (evt.rise) begin
        bit_cnt <= nxt;
        fsync_o <= master & (long_sync ? in_slot_nxt : (nxt == last));
        dout_oe <= in_slot_nxt & ~burst;
        if (nxt == '0) begin
          sh     <= load_val << 1;
          dout_o <= load_val[W-1] & ~burst;
          tx_req <= ~burst;
          if (!tx_valid) pend_vld <= 1'b0;
        end else if (in_slot_nxt) begin
          sh     <= sh << 1;
          dout_o <= sh[W-1] & ~burst;
        end else begin
          dout_o <= 1'b0;
        end
      end
      if (evt.fall) begin
        fs_prev <= evt.sync;
        if (!master) begin
          if (long_sync) begin
            if (fs_edge) bit_cnt <= '0;
          end else if (evt.sync) begin
            bit_cnt <= last;
          end
        end
        if (eff < nbits) begin
          rx_sh <= {rx_sh[W-3:0], evt.din};
          if (eff == nbits - 1'b1) begin
            rx_data  <= {rx_sh, evt.din} & mask;
            rx_valid <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pcm_voice_port.sv
module pcm_voice_port
  import pcm_voice_pkg::*;
#(
  parameter int SAMPLE_W    = 16,
  parameter int FRAME_W     = 8,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cfg_master,
  input  logic                          cfg_long_sync,
  input  logic                          cfg_burst,
  input  logic [$clog2(SAMPLE_W+1)-1:0] cfg_slot_bits,
  input  logic [FRAME_W-1:0]            cfg_frame_len,
  input  logic [DIV_W-1:0]              cfg_half_div,
  input  logic [SAMPLE_W-1:0]           tx_data,
  input  logic                          tx_valid,
  output logic                          tx_req,
  output logic [SAMPLE_W-1:0]           rx_data,
  output logic                          rx_valid,
  output logic                          bclk_o,
  output logic                          bclk_oe,
  input  logic                          bclk_i,
  output logic                          fsync_o,
  output logic                          fsync_oe,
  input  logic                          fsync_i,
  output logic                          dout_o,
  output logic                          dout_oe,
  input  logic                          din_i
);
  localparam int NB_W = $clog2(SAMPLE_W + 1);

  logic     m_rise, m_fall, s_rise, s_fall, s_sync, s_din;
  pcm_evt_t evt;

  pcm_bclk_master #(.DIV_W(DIV_W)) u_mclk (
    .clk(clk), .rst(rst), .run(cfg_master), .half(cfg_half_div),
    .bclk(bclk_o), .rise(m_rise), .fall(m_fall)
  );

  pcm_bus_sampler #(.STAGES(SYNC_STAGES)) u_samp (
    .clk(clk), .rst(rst), .bclk_in(bclk_i), .sync_in(fsync_i), .din_in(din_i),
    .rise(s_rise), .fall(s_fall), .sync_s(s_sync), .din_s(s_din)
  );

  always_comb begin
    if (cfg_master) evt = '{rise: m_rise, fall: m_fall, sync: 1'b0, din: din_i};
    else            evt = '{rise: s_rise, fall: s_fall, sync: s_sync, din: s_din};
  end

  pcm_slot_engine #(.W(SAMPLE_W), .CNT_W(FRAME_W), .NB_W(NB_W)) u_eng (
    .clk(clk), .rst(rst), .master(cfg_master), .long_sync(cfg_long_sync),
    .burst(cfg_burst), .slot_bits(cfg_slot_bits), .frame_len(cfg_frame_len),
    .evt(evt), .tx_data(tx_data), .tx_valid(tx_valid),
    .fsync_o(fsync_o), .dout_o(dout_o), .dout_oe(dout_oe), .tx_req(tx_req),
    .rx_data(rx_data), .rx_valid(rx_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_oe  <= 1'b0;
      fsync_oe <= 1'b0;
    end else begin
      bclk_oe  <= cfg_master;
      fsync_oe <= cfg_master;
    end
  end
endmodule

// File: rtl/pcm_voice_port_chk.sv
module pcm_voice_port_chk (
  input logic clk,
  input logic rst,
  input logic cfg_master,
  input logic cfg_burst,
  input logic bclk_o,
  input logic bclk_oe,
  input logic fsync_o,
  input logic fsync_oe,
  input logic dout_o,
  input logic dout_oe,
  input logic tx_req,
  input logic rx_valid
);
  // R7
  rx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
  // R8
  txreq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tx_req |=> !tx_req);
  // R5
  dout_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_master && $past(cfg_master) && !$stable(dout_o)) |-> $rose(bclk_o));
  // R3
  fsync_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_master && $past(cfg_master) && !$stable(fsync_o)) |-> $rose(bclk_o));
  // R9
  slave_release_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_master && !$past(cfg_master)) |-> (!bclk_oe && !fsync_oe));
  // R10
  burst_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dout_oe) |-> !$past(cfg_burst));
  // R10
  burst_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    tx_req |-> !$past(cfg_burst));
endmodule

bind pcm_voice_port pcm_voice_port_chk u_chk (
  .clk(clk), .rst(rst), .cfg_master(cfg_master), .cfg_burst(cfg_burst),
  .bclk_o(bclk_o), .bclk_oe(bclk_oe), .fsync_o(fsync_o), .fsync_oe(fsync_oe),
  .dout_o(dout_o), .dout_oe(dout_oe), .tx_req(tx_req), .rx_valid(rx_valid)
);

// File: tb/pcm_voice_port_bench.sv
`timescale 1ns/1ps
module pcm_voice_port_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_master = 1'b1, cfg_long_sync = 1'b0, cfg_burst = 1'b0;
  logic [4:0]  cfg_slot_bits = 5'd8;
  logic [7:0]  cfg_frame_len = 8'd12, cfg_half_div = 8'd2;
  logic [15:0] tx_data = '0, rx_data;
  logic        tx_valid = 1'b0, tx_req, rx_valid;
  logic        bclk_o, bclk_oe, bclk_i = 1'b0;
  logic        fsync_o, fsync_oe, fsync_i = 1'b0;
  logic        dout_o, dout_oe, din_i, din_drv = 1'b0, lb = 1'b1;

  int tests = 0, fails = 0, done = 0;
  int rx_cnt = 0, txr_cnt = 0, oe_cnt = 0;
  logic [15:0] rx_last = '0;

  assign din_i = lb ? dout_o : din_drv;

  always #4 clk = ~clk;

  pcm_voice_port u_pcm_voice_port (
    .clk(clk), .rst(rst), .cfg_master(cfg_master), .cfg_long_sync(cfg_long_sync),
    .cfg_burst(cfg_burst), .cfg_slot_bits(cfg_slot_bits), .cfg_frame_len(cfg_frame_len),
    .cfg_half_div(cfg_half_div), .tx_data(tx_data), .tx_valid(tx_valid), .tx_req(tx_req),
    .rx_data(rx_data), .rx_valid(rx_valid), .bclk_o(bclk_o), .bclk_oe(bclk_oe),
    .bclk_i(bclk_i), .fsync_o(fsync_o), .fsync_oe(fsync_oe), .fsync_i(fsync_i),
    .dout_o(dout_o), .dout_oe(dout_oe), .din_i(din_i)
  );

  always @(negedge clk) begin
    if (rx_valid) begin rx_cnt <= rx_cnt + 1; rx_last <= rx_data; end
    if (tx_req)   txr_cnt <= txr_cnt + 1;
    if (dout_oe)  oe_cnt  <= oe_cnt + 1;
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_txreq();
    do @(negedge clk); while (tx_req !== 1'b1);
  endtask

  // Records one master frame starting just after its first rising edge.
  task automatic collect_master(input int n, input int fl, input int h, input logic lng,
                                input logic [15:0] s);
    logic [63:0] dv = '0, ov = '0, fv = '0, ed = '0, eo = '0, ef = '0;
    logic [15:0] rxv = '0;
    logic [15:0] m = 16'((32'd1 << n) - 1);
    int bad = 0;
    logic got = 1'b0;
    for (int p = 0; p < fl; p++) begin
      int c = 0;
      do begin @(negedge clk); c++; if (rx_valid) begin got = 1'b1; rxv = rx_data; end end
      while (bclk_o !== 1'b0);
      if (c != h) bad++;
      dv[p] = dout_o; ov[p] = dout_oe; fv[p] = fsync_o;
      c = 0;
      do begin @(negedge clk); c++; if (rx_valid) begin got = 1'b1; rxv = rx_data; end end
      while (bclk_o !== 1'b1);
      if (c != h) bad++;
    end
    for (int p = 0; p < fl; p++) begin
      eo[p] = (p < n);
      ed[p] = (p < n) ? s[n-1-p] : 1'b0;
      ef[p] = lng ? (p < n) : (p == fl - 1);
    end
    chk("R2", "bclk phase length errors", 64'(bad), 64'd0);
    chk("R5", "data-out bits per period", dv, ed);
    chk("R6", "data-out enable per period", ov, eo);
    chk(lng ? "R4" : "R3", "frame sync per period", fv, ef);
    chk("R7", "loopback sample", {47'd0, got, rxv}, {47'd0, 1'b1, s & m});
    chk("R8", "request at next frame start", 64'(tx_req), 64'd1);
  endtask

  task automatic t_reset();
    cfg_master = 1'b1; cfg_long_sync = 1'b0; cfg_burst = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "bclk_o in reset", 64'(bclk_o), 64'd0);
    chk("R1", "fsync_o in reset", 64'(fsync_o), 64'd0);
    chk("R1", "dout_oe in reset", 64'(dout_oe), 64'd0);
    chk("R1", "rx_valid in reset", 64'(rx_valid), 64'd0);
    chk("R1", "tx_req in reset", 64'(tx_req), 64'd0);
  endtask

  task automatic t_master(input int n, input int fl, input int h, input logic lng,
                          input logic [15:0] s);
    cfg_master = 1'b1; cfg_long_sync = lng; cfg_burst = 1'b0; lb = 1'b1;
    cfg_slot_bits = 5'(n); cfg_frame_len = 8'(fl); cfg_half_div = 8'(h);
    tx_valid = 1'b0;
    do_reset();
    wait_txreq();
    tx_data = s; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    wait_txreq();
    collect_master(n, fl, h, lng, s);
  endtask

  // R8: no sample written after the last request, so the frame is all zeros
  task automatic t_underrun(input int n, input int fl, input int h, input logic lng);
    collect_master(n, fl, h, lng, 16'h0000);
  endtask

  task automatic t_slave(input logic lng, input logic bst, input logic [15:0] s,
                         input logic [15:0] pat);
    int n = 12, fl = 16, h = 5;
    logic [63:0] dv = '0, ov = '0, ed = '0, eo = '0;
    int rx0, tx0, oe0;
    logic [15:0] m = 16'((32'd1 << n) - 1);
    cfg_master = 1'b0; cfg_long_sync = lng; cfg_burst = bst; lb = 1'b0;
    cfg_slot_bits = 5'(n); cfg_frame_len = 8'(fl);
    tx_data = s; tx_valid = 1'b1;
    bclk_i = 1'b0; fsync_i = 1'b0; din_drv = 1'b0;
    do_reset();
    @(negedge clk);
    rx0 = rx_cnt; tx0 = txr_cnt; oe0 = oe_cnt;
    for (int f = 0; f < 3; f++) begin
      for (int q = 0; q < fl; q++) begin
        bclk_i  = 1'b1;
        fsync_i = lng ? (q < n) : (q == fl - 1);
        din_drv = (q < n) ? pat[n-1-q] : 1'b0;
        repeat (h) @(negedge clk);
        bclk_i = 1'b0;
        if (f == 2) begin dv[q] = dout_o; ov[q] = dout_oe; end
        repeat (h) @(negedge clk);
      end
    end
    repeat (6) @(negedge clk);
    for (int q = 0; q < fl; q++) begin
      eo[q] = (q < n);
      ed[q] = (q < n) ? s[n-1-q] : 1'b0;
    end
    chk("R9", "slave bus enables", {62'd0, bclk_oe, fsync_oe}, 64'd0);
    chk("R7", "slave received sample", {47'd0, (rx_cnt > rx0), rx_last},
        {47'd0, 1'b1, pat & m});
    if (!bst) begin
      chk("R9", "slave aligned data-out bits", dv, ed);
      chk("R6", "slave data-out enable", ov, eo);
    end else begin
      chk("R10", "burst data-out enable cycles", 64'(oe_cnt - oe0), 64'd0);
      chk("R10", "burst transmit requests", 64'(txr_cnt - tx0), 64'd0);
    end
    tx_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (done == 0) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_master(8, 12, 2, 1'b0, 16'hA5C3);   // R3 short sync, upper bits dropped
    t_underrun(8, 12, 2, 1'b0);           // R8 zero fill
    t_master(16, 20, 3, 1'b1, 16'h9E61);  // R4 long sync, full width
    t_slave(1'b0, 1'b0, 16'h0B5A, 16'h0C3D);
    t_slave(1'b1, 1'b0, 16'h0D27, 16'h0A96);
    t_slave(1'b0, 1'b1, 16'h0FFF, 16'h0E4B); // R10 burst
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule